// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Burner

This block is a register-mapped sequencer that burns one 32-bit word of a one-time-programmable fuse array per request. Software first places a 16-bit unlock key and the target word address in the control register, then writes the value to burn into the data register. The block takes its own copy of the address and reads the current contents of the fuse word. It removes bits that are already blown from the request. It then visits every bit position in turn and fires the program strobe only for the bits that remain, shifting the data register right by one place per position.

Timing comes from a timing register that holds the strobe width, the idle padding around each strobe and the read-strobe width. A counted recovery gap follows every burn. A request that arrives during that gap is held and starts automatically when the gap ends. Requests to a word the array reports as locked, and register writes made while an operation runs, are refused and raise an error flag. That flag must be cleared before another burn is accepted.

Top module: `fuse_prog_ctrl`

## Requirements
- R1: The control register sits at offset 0x00 with the word address in bits [7:0], busy in bit 8 (read-only), error in bit 9, a reload flag in bit 10 and the key in bits [31:16]. A write at offset 0x04 ORs its data into the writable fields and a write at offset 0x08 clears the fields where its data has ones. All fields reset to 0.
- R2: A burn starts only if the key field holds 0x3E77 when the data register is written. Any accepted data-register write clears the key field to 0.
- R3: An accepted burn sets busy from the next cycle. The block copies the address at that moment, and the fuse address output keeps that copy steady for as long as busy stays high.
- R4: Before burning, the block samples the fuse word and removes its set bits from the data. It strobes exactly the bits that are 1 in the data and 0 in the fuse word, so the word becomes old OR data.
- R5: Each program strobe lasts STROBE_PROG cycles, with a width of 0 treated as 1. There are at least 2*(RELAX+1) idle cycles between two strobes of one burn.
- R6: The data register sits at offset 0x20. During a burn it shifts right with zero fill once per bit position, so it reads 0 when the burn is done.
- R7: The timing register sits at offset 0x10 with STROBE_PROG in bits [11:0], RELAX in bits [15:12] and STROBE_READ in bits [21:16]. Bits [27:22] always read their reset value and ignore writes, and bits [31:28] read 0. The reset value is 0x0AC21190.
- R8: A burn request to a word flagged locked produces no read strobe, no program strobe and no busy, and sets error. While error is set, a keyed data write starts nothing.
- R9: Any write to a mapped register while busy is high changes nothing and sets error. Reads are always allowed.
- R10: After a burn, GAP_CYCLES cycles follow the RELAX+1 trailing idle cycles before any new read strobe. A request accepted during that gap sets busy at once and starts its read strobe exactly when the gap ends.
- R11: The read strobe before the mask lasts STROBE_READ cycles, with a width of 0 treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| fuse_addr | output | 7 | Fuse word address |
| fuse_bit | output | 5 | Bit position being burned |
| fuse_prog | output | 1 | Program strobe |
| fuse_read | output | 1 | Read strobe |
| fuse_rdata | input | 32 | Current contents of the addressed fuse word |
| fuse_locked | input | 1 | Addressed fuse word is locked |

## Verification
The assertions check on every cycle that the fuse address stays steady while busy is high, that every program strobe lands on a bit that survived the mask, and that no read strobe appears while the recovery gap is still counting. They also check that an accepted data write clears the key, and that a write made while busy or a request to a locked word raises error. Only the scenarios can show the end-to-end results: the final fuse contents after the mask, the exact strobe count and widths, the value of the shifting data register in the middle of a burn, the exact gap length before a held request starts, and the timing register's read-only bits.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_SET  = 8'h04;
  localparam logic [7:0] OFF_CLR  = 8'h08;
  localparam logic [7:0] OFF_TIME = 8'h10;
  localparam logic [7:0] OFF_DATA = 8'h20;

  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

  localparam int BUSY_POS   = 8;
  localparam int ERR_POS    = 9;
  localparam int RELOAD_POS = 10;

  typedef struct packed {
    logic [5:0]  strobe_read;
    logic [3:0]  relax;
    logic [11:0] strobe_prog;
  } fpc_timing_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_SCAN,
    ST_PRE,
    ST_STROBE,
    ST_POST,
    ST_GAP
  } fpc_state_t;

endpackage

// File: rtl/fpc_regs.sv
module fpc_regs
  import fpc_pkg::*;
#(
  parameter int          ADDR_W     = 7,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] TIMING_RST = 32'h0AC2_1190
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  input  logic              fuse_locked,
  input  logic [DATA_W-1:0] data_q,
  output fpc_timing_t       timing,
  output logic [ADDR_W-1:0] ctrl_addr,
  output logic              data_load,
  output logic              go
);

  localparam logic [5:0] TIME_KEEP = TIMING_RST[27:22];

  logic [7:0]  addr_q;
  logic [15:0] key_q;
  logic        err_q;
  logic        reload_q;
  fpc_timing_t time_q;

  logic wr, rd, wr_ok, known, key_ok, prog_req;
  logic hit_ctrl, hit_set, hit_clr, hit_time, hit_data;

  always_comb begin
    wr       = bus_sel & bus_wr;
    rd       = bus_sel & ~bus_wr;
    hit_ctrl = (bus_addr == OFF_CTRL);
    hit_set  = (bus_addr == OFF_SET);
    hit_clr  = (bus_addr == OFF_CLR);
    hit_time = (bus_addr == OFF_TIME);
    hit_data = (bus_addr == OFF_DATA);
    known    = hit_ctrl | hit_set | hit_clr | hit_time | hit_data;
    wr_ok    = wr & ~busy;
    key_ok   = (key_q == UNLOCK_KEY);
    data_load = wr_ok & hit_data;
    prog_req = data_load & key_ok & ~err_q;
    go       = prog_req & ~fuse_locked;
  end

  assign timing    = time_q;
  assign ctrl_addr = addr_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      key_q    <= '0;
      err_q    <= 1'b0;
      reload_q <= 1'b0;
      time_q   <= TIMING_RST[21:0];
    end else if (wr && busy && known) begin
      err_q <= 1'b1;
    end else if (wr_ok) begin
      if (hit_ctrl) begin
        addr_q   <= bus_wdata[7:0];
        err_q    <= bus_wdata[ERR_POS];
        reload_q <= bus_wdata[RELOAD_POS];
        key_q    <= bus_wdata[31:16];
      end
      if (hit_set) begin
        addr_q   <= addr_q | bus_wdata[7:0];
        err_q    <= err_q | bus_wdata[ERR_POS];
        reload_q <= reload_q | bus_wdata[RELOAD_POS];
        key_q    <= key_q | bus_wdata[31:16];
      end
      if (hit_clr) begin
        addr_q   <= addr_q & ~bus_wdata[7:0];
        err_q    <= err_q & ~bus_wdata[ERR_POS];
        reload_q <= reload_q & ~bus_wdata[RELOAD_POS];
        key_q    <= key_q & ~bus_wdata[31:16];
      end
      if (hit_time) begin
        time_q <= bus_wdata[21:0];
      end
      if (hit_data) begin
        key_q <= '0;
        if (prog_req && fuse_locked) err_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      if (hit_ctrl)
        bus_rdata <= {key_q, 5'b0, reload_q, err_q, busy, addr_q};
      else if (hit_time)
        bus_rdata <= {4'b0, TIME_KEEP, time_q};
      else if (hit_data)
        bus_rdata <= 32'(data_q);
      else
        bus_rdata <= '0;
    end
  end

  AST_KEY_CLEARED: assert property (@(posedge clk) disable iff (rst)
    data_load |=> (key_q == 16'h0)); // R2

  AST_BUSY_WRITE_ERR: assert property (@(posedge clk) disable iff (rst)
    (wr && busy && known) |=> err_q); // R9

  AST_LOCK_ERR: assert property (@(posedge clk) disable iff (rst)
    (prog_req && fuse_locked) |=> (err_q && !busy)); // R8

endmodule

// File: rtl/fpc_burn_seq.sv
module fpc_burn_seq
  import fpc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 7,
  parameter int GAP_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  fpc_timing_t       timing,
  input  logic [ADDR_W-1:0] ctrl_addr,
  input  logic              data_load,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              go,
  input  logic [DATA_W-1:0] fuse_rdata,
  output logic              busy,
  output logic [DATA_W-1:0] data_q,
  output logic [ADDR_W-1:0] fuse_addr,
  output logic [$clog2(DATA_W)-1:0] fuse_bit,
  output logic              fuse_prog,
  output logic              fuse_read
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam int CNT_W = 12;
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  fpc_state_t        state;
  logic [DATA_W-1:0] shreg;
  logic [ADDR_W-1:0] lat_addr;
  logic [IDX_W-1:0]  bit_idx;
  logic [CNT_W-1:0]  cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic              pending;
  logic [CNT_W-1:0]  rd_len, prog_len, pad_len;

  always_comb begin
    rd_len   = (timing.strobe_read == 6'd0) ? CNT_W'(1) : CNT_W'(timing.strobe_read);
    prog_len = (timing.strobe_prog == 12'd0) ? CNT_W'(1) : timing.strobe_prog;
    pad_len  = CNT_W'(timing.relax);
    busy     = (state != ST_IDLE) && !((state == ST_GAP) && !pending);
  end

  assign data_q    = shreg;
  assign fuse_addr = busy ? lat_addr : ctrl_addr;
  assign fuse_bit  = bit_idx;
  assign fuse_prog = (state == ST_STROBE);
  assign fuse_read = (state == ST_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      lat_addr <= '0;
      bit_idx  <= '0;
      cnt      <= '0;
      gap_cnt  <= '0;
      pending  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (data_load) shreg <= data_wdata;
          if (go) begin
            lat_addr <= ctrl_addr;
            bit_idx  <= '0;
            cnt      <= rd_len - 1'b1;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          if (cnt == '0) begin
            shreg <= shreg & ~fuse_rdata;
            state <= ST_SCAN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SCAN: begin
          if (shreg[0]) begin
            cnt   <= pad_len;
            state <= ST_PRE;
          end else begin
            shreg <= shreg >> 1;
            if (bit_idx == LAST_IDX) begin
              gap_cnt <= GAP_W'(GAP_CYCLES - 1);
              bit_idx <= '0;
              state   <= ST_GAP;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        ST_PRE: begin
          if (cnt == '0) begin
            cnt   <= prog_len - 1'b1;
            state <= ST_STROBE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            cnt   <= pad_len;
            state <= ST_POST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_POST: begin
          if (cnt == '0) begin
            shreg <= shreg >> 1;
            if (bit_idx == LAST_IDX) begin
              gap_cnt <= GAP_W'(GAP_CYCLES - 1);
              bit_idx <= '0;
              state   <= ST_GAP;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              state   <= ST_SCAN;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (data_load) shreg <= data_wdata;
          if (go) begin
            lat_addr <= ctrl_addr;
            pending  <= 1'b1;
          end
          if (gap_cnt == '0) begin
            if (pending || go) begin
              pending <= 1'b0;
              bit_idx <= '0;
              cnt     <= rd_len - 1'b1;
              state   <= ST_READ;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(fuse_addr)); // R3

  AST_PROG_MASKED: assert property (@(posedge clk) disable iff (rst)
    fuse_prog |-> shreg[0]); // R4

  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP && gap_cnt != '0) |=> !fuse_read); // R10

endmodule

// File: rtl/fuse_prog_ctrl.sv
module fuse_prog_ctrl
  import fpc_pkg::*;
#(
  parameter int          ADDR_W     = 7,
  parameter int          DATA_W     = 32,
  parameter int          GAP_CYCLES = 200,
  parameter logic [31:0] TIMING_RST = 32'h0AC2_1190
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [ADDR_W-1:0] fuse_addr,
  output logic [$clog2(DATA_W)-1:0] fuse_bit,
  output logic              fuse_prog,
  output logic              fuse_read,
  input  logic [DATA_W-1:0] fuse_rdata,
  input  logic              fuse_locked
);

  fpc_timing_t       timing;
  logic [ADDR_W-1:0] ctrl_addr;
  logic              data_load, go, busy;
  logic [DATA_W-1:0] data_q;

  fpc_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .TIMING_RST(TIMING_RST)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .fuse_locked(fuse_locked),
    .data_q     (data_q),
    .timing     (timing),
    .ctrl_addr  (ctrl_addr),
    .data_load  (data_load),
    .go         (go)
  );

  fpc_burn_seq #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .GAP_CYCLES(GAP_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .timing    (timing),
    .ctrl_addr (ctrl_addr),
    .data_load (data_load),
    .data_wdata(bus_wdata[DATA_W-1:0]),
    .go        (go),
    .fuse_rdata(fuse_rdata),
    .busy      (busy),
    .data_q    (data_q),
    .fuse_addr (fuse_addr),
    .fuse_bit  (fuse_bit),
    .fuse_prog (fuse_prog),
    .fuse_read (fuse_read)
  );

endmodule

// File: tb/sim_fuse_prog_ctrl.sv
module sim_fuse_prog_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 50;
  localparam int T_PROG     = 3;
  localparam int T_RELAX    = 1;
  localparam int T_READ     = 2;
  localparam logic [31:0] KEY_HI = 32'h3E77_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  fuse_addr;
  logic [4:0]  fuse_bit;
  logic        fuse_prog, fuse_read, fuse_locked;
  logic [31:0] fuse_rdata;

  logic [31:0] init_mem [0:127];
  logic [31:0] burn_mem [0:127];
  logic        lock_mem [0:127];

  assign fuse_rdata  = init_mem[fuse_addr] | burn_mem[fuse_addr];
  assign fuse_locked = lock_mem[fuse_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_prog_ctrl #(.GAP_CYCLES(GAP)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fuse_addr(fuse_addr), .fuse_bit(fuse_bit), .fuse_prog(fuse_prog),
    .fuse_read(fuse_read), .fuse_rdata(fuse_rdata), .fuse_locked(fuse_locked)
  );

  int checks = 0, errors = 0;
  int cyc = 0, strobes = 0, reads = 0, bad_len = 0;
  int prog_run = 0, rd_run = 0, idle_run = 0, min_gap = 1000;
  int fall_cyc = 0, last_gap = 0, last_rd_len = 0;
  bit prev_prog = 0, prev_read = 0, seen_strobe = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < 128; i++) burn_mem[i] = '0;
    end else begin
      if (fuse_prog) begin
        if (!prev_prog) begin
          strobes++;
          if (seen_strobe && idle_run < min_gap) min_gap = idle_run;
          burn_mem[fuse_addr][fuse_bit] = 1'b1;
        end
        prog_run++;
        idle_run = 0;
        seen_strobe = 1;
      end else begin
        if (prev_prog) begin
          if (prog_run != T_PROG) bad_len++;
          prog_run = 0;
          fall_cyc = cyc;
        end
        idle_run++;
      end
      if (fuse_read) begin
        if (!prev_read) begin
          reads++;
          last_gap = cyc - fall_cyc;
          seen_strobe = 0;
        end
        rd_run++;
      end else if (prev_read) begin
        last_rd_len = rd_run;
        rd_run = 0;
      end
    end
    prev_prog = fuse_prog;
    prev_read = fuse_read;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = off; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = off;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 3000; i++) begin
      bus_read(8'h00, c);
      if (!c[8]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(8'h00, d); check(d == 32'h0, "R1 ctrl reset", d, 32'h0);
    bus_read(8'h10, d); check(d == 32'h0AC2_1190, "R7 timing reset", d, 32'h0AC2_1190);
    bus_read(8'h20, d); check(d == 32'h0, "R6 data reset", d, 32'h0);
  endtask

  task automatic t_alias();
    logic [31:0] d;
    bus_write(8'h00, 32'h0000_005A);
    bus_write(8'h04, 32'h0000_0400);
    bus_read(8'h00, d); check(d == 32'h0000_045A, "R1 set alias", d, 32'h0000_045A);
    bus_write(8'h08, 32'h0000_040A);
    bus_read(8'h00, d); check(d == 32'h0000_0050, "R1 clear alias", d, 32'h0000_0050);
  endtask

  task automatic t_timing();
    logic [31:0] d;
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h10, d); check(d == 32'h0AFF_FFFF, "R7 reserved bits kept", d, 32'h0AFF_FFFF);
    bus_write(8'h10, {10'b0, 6'(T_READ), 4'(T_RELAX), 12'(T_PROG)});
    bus_read(8'h10, d); check(d == 32'h0AC2_1003, "R7 field placement", d, 32'h0AC2_1003);
  endtask

  task automatic t_nokey();
    logic [31:0] d;
    int r0 = reads;
    bus_write(8'h00, 32'h0000_0005);
    bus_write(8'h20, 32'h0000_000F);
    repeat (5) @(negedge clk);
    check(reads == r0, "R2 no key no access", 32'(reads), 32'(r0));
    bus_read(8'h20, d); check(d == 32'h0000_000F, "R2 data held without key", d, 32'hF);
  endtask

  task automatic t_program();
    logic [31:0] d;
    int s0;
    init_mem[5] = 32'h0000_00F0;
    bus_write(8'h00, KEY_HI | 32'h5);
    bus_read(8'h00, d); check(d == 32'h3E77_0005, "R1 key field", d, 32'h3E77_0005);
    s0 = strobes;
    bus_write(8'h20, 32'h0000_0FF0);
    bus_read(8'h00, d); check(d == 32'h0000_0105, "R3 busy set, R2 key cleared", d, 32'h0000_0105);
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_write(8'h00, KEY_HI | 32'h9);
    wait_idle();
    bus_read(8'h00, d); check(d == 32'h0000_0205, "R9 busy writes rejected, error set", d, 32'h0000_0205);
    d = init_mem[5] | burn_mem[5];
    check(d == 32'h0000_0FF0, "R4 word is old OR data", d, 32'h0000_0FF0);
    check(strobes - s0 == 4, "R4 only unblown bits strobed", 32'(strobes - s0), 32'd4);
    check(bad_len == 0, "R5 strobe width", 32'(bad_len), 32'd0);
    check(min_gap >= 2*(T_RELAX+1), "R5 idle between strobes", 32'(min_gap), 32'(2*(T_RELAX+1)));
    check(last_rd_len == T_READ, "R11 read strobe width", 32'(last_rd_len), 32'(T_READ));
    bus_read(8'h20, d); check(d == 32'h0, "R6 data shifted out", d, 32'h0);
    d = burn_mem[9];
    check(d == 32'h0, "R3 address copy unchanged", d, 32'h0);
    bus_write(8'h08, 32'h0000_0200);
    repeat (GAP + 5) @(negedge clk);
  endtask

  task automatic t_shift();
    logic [31:0] d;
    bus_write(8'h00, KEY_HI | 32'h6);
    bus_write(8'h20, 32'h8000_0003);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (fuse_prog && fuse_bit == 5'd1) break;
    end
    bus_read(8'h20, d); check(d == 32'h4000_0001, "R6 shift right zero fill", d, 32'h4000_0001);
    wait_idle();
    repeat (GAP + 5) @(negedge clk);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    int r0;
    lock_mem[7] = 1'b1;
    r0 = reads;
    bus_write(8'h00, KEY_HI | 32'h7);
    bus_write(8'h20, 32'h0000_0001);
    bus_read(8'h00, d); check(d == 32'h0000_0207, "R8 locked: error, no busy", d, 32'h0000_0207);
    check(reads == r0, "R8 locked: no array access", 32'(reads), 32'(r0));
    bus_write(8'h08, 32'h0000_00FF);
    bus_write(8'h04, KEY_HI | 32'h8);
    bus_write(8'h20, 32'h0000_0001);
    repeat (5) @(negedge clk);
    check(reads == r0, "R8 error blocks request", 32'(reads), 32'(r0));
    bus_write(8'h08, 32'h0000_0200);
    bus_write(8'h04, KEY_HI);
    bus_write(8'h20, 32'h0000_0001);
    wait_idle();
    d = burn_mem[8];
    check(d == 32'h1, "R8 burn after error cleared", d, 32'h1);
    repeat (GAP + 5) @(negedge clk);
  endtask

  task automatic t_gap();
    logic [31:0] d;
    bus_write(8'h00, KEY_HI | 32'd10);
    bus_write(8'h20, 32'h8000_0001);
    wait_idle();
    bus_write(8'h00, KEY_HI | 32'd11);
    bus_write(8'h20, 32'h0000_0002);
    bus_read(8'h00, d); check(d[8] == 1'b1, "R10 held request shows busy", d, 32'h0000_010B);
    wait_idle();
    check(last_gap == T_RELAX + 1 + GAP, "R10 recovery gap length", 32'(last_gap), 32'(T_RELAX + 1 + GAP));
    d = burn_mem[11];
    check(d == 32'h2, "R10 held request burned", d, 32'h2);
    d = burn_mem[10];
    check(d == 32'h8000_0001, "R4 blank word burned", d, 32'h8000_0001);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      init_mem[i] = '0;
      lock_mem[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_alias();
    t_timing();
    t_nokey();
    t_program();
    t_shift();
    t_lock();
    t_gap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule